// File: doc/BRIEF.md
# Pipelined Burst SRAM with Load/Advance Control

This block models a synchronous static memory whose read and write commands share a single pipeline, so no dead cycle is needed when the direction changes. The word is 36 bits wide, split into four 9-bit byte lanes. On every enabled rising edge, one select input chooses between two cases. The first loads a new external address together with a new operation. The second advances an internal burst counter and repeats the operation that the last load chose.

A load where any of the three chip selects is inactive becomes a deselect cycle. Advance cycles that follow a deselect stay deselected. Read data appears two enabled edges after the address edge. Write data and byte strobes are taken on the edge two enabled edges after the address edge. The data bus is represented by a data output and a drive-enable output. A clock-enable input freezes the whole block. A sleep input overrides every other input and keeps the bus released.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low, `dout_en` is 0. After reset the burst state is deselected, so advance cycles perform no access. Reset does not alter stored data.
- R2: A load edge (`adv_ld`=0, `cken_n`=0) with `sel0_n`=1, `sel1`=0 or `sel2_n`=1 is a deselect. It reads nothing, writes nothing, and the bus stays released. Advance edges after a deselect continue the deselect whatever the selects and `wr_n` are.
- R3: A load edge with all selects active and `wr_n`=1 starts a read. The word stored at the operation's address is on `dout`, with `dout_en`=1 (when `oe_n`=0), just after the second enabled edge following the address edge. It holds until the next enabled edge.
- R4: A load edge with all selects active and `wr_n`=0 starts a write. On the second enabled edge after the address edge, lane k (bits 9k+8..9k) is written from `din` exactly when `bw_n[k]`=0. Any subset of lanes may be written.
- R5: A write whose data edge has `bw_n`=4'hF is an abort, and the stored word is unchanged.
- R6: Each advance edge after a read or write load increments the two low address bits, wrapping 3→0. The upper address bits stay as loaded. The edge repeats the loaded operation, and `addr` and `wr_n` are ignored on it.
- R7: `oe_n`=1 releases the bus without a clock edge (dummy read). Lowering it again drives the pending read word.
- R8: After a data edge that performed a write operation, `dout_en` is 0 regardless of `oe_n`.
- R9: An edge with `cken_n`=1 changes no state. It performs no write, and `dout` and `dout_en` hold.
- R10: While `sleep`=1, `dout_en` is 0 and no write takes place. Operations in flight are dropped. After sleep the burst state is deselected, and stored data is kept.
- R11: A read loaded on the edge right after a write load to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| cken_n | input | 1 | Clock enable, active low; high stalls the edge |
| adv_ld | input | 1 | 0 = load address and operation, 1 = advance burst |
| wr_n | input | 1 | Operation on load edges: 0 = write, 1 = read |
| bw_n | input | 4 | Byte-lane write strobes, active low, lane k = bits 9k+8..9k |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep request, overrides all other inputs |
| addr | input | ADDR_W | External word address |
| din | input | 36 | Write data |
| dout | output | 36 | Read data |
| dout_en | output | 1 | Drive enable for the data bus |

## Verification
The bench starts bursts at every low-address offset. A counter that carried into the upper bits, or one that did not wrap, would write and read the wrong word of each group. Advance cycles drive the opposite `wr_n` and a junk address, so a design that resampled them would flip the operation or jump address. Every byte-strobe pattern is written and read back, and all-high is the abort case. A stall placed at a write's data edge, and sleep placed over an in-flight write, must leave memory untouched, while a stalled read must keep its word on the bus. Deselect by each chip select, continue-deselect after sleep and reset, and a read issued right behind a write to the same address target designs that leak accesses or return stale data.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/burst_sram_seq.sv
// Command decode and burst address sequencer (pipeline stage 1).
module burst_sram_seq
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              sleep,
    input  logic              chip_ok,
    input  logic              adv,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] ext_addr,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output op_e               burst_op
);

    localparam logic [BURST_W-1:0] ONE = {{(BURST_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        op_e               burst;
        op_e               s1;
        logic [ADDR_W-1:0] cur;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sleep) begin
            st_d.burst = OP_IDLE;
            st_d.s1    = OP_IDLE;
        end else if (step) begin
            if (!adv) begin
                if (!chip_ok) begin
                    st_d.burst = OP_IDLE;
                    st_d.s1    = OP_IDLE;
                end else begin
                    st_d.burst = rd_sel ? OP_READ : OP_WRITE;
                    st_d.s1    = rd_sel ? OP_READ : OP_WRITE;
                    st_d.cur   = ext_addr;
                end
            end else if (st_q.burst == OP_IDLE) begin
                st_d.s1 = OP_IDLE;
            end else begin
                st_d.cur[BURST_W-1:0] = st_q.cur[BURST_W-1:0] + ONE;
                st_d.s1               = st_q.burst;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{burst: OP_IDLE, s1: OP_IDLE, cur: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_op    = st_q.s1;
    assign s1_addr  = st_q.cur;
    assign burst_op = st_q.burst;

endmodule

// File: rtl/burst_sram_array.sv
// Storage lanes and pipeline stage 2 (data edge).
module burst_sram_array
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9,
    localparam int DATA_W = BYTES * BYTE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              sleep,
    input  op_e               s1_op,
    input  logic [ADDR_W-1:0] s1_addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BYTES-1:0]  wmask_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_live,
    output op_e               s2_op
);

    typedef struct packed {
        op_e               s2;
        logic [ADDR_W-1:0] s2_addr;
        logic              live;
        logic [DATA_W-1:0] q;
    } arr_t;

    arr_t              st_d, st_q;
    logic [BYTES-1:0]  lane_we;
    logic [DATA_W-1:0] lane_rd;

    always_comb begin
        st_d    = st_q;
        lane_we = '0;
        if (sleep) begin
            st_d.s2   = OP_IDLE;
            st_d.live = 1'b0;
        end else if (step) begin
            st_d.s2      = s1_op;
            st_d.s2_addr = s1_addr;
            st_d.live    = (st_q.s2 == OP_READ);
            if (st_q.s2 == OP_READ) begin
                st_d.q = lane_rd;
            end
            if (st_q.s2 == OP_WRITE) begin
                lane_we = ~wmask_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s2: OP_IDLE, s2_addr: '0, live: 1'b0, q: '0};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_q [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[b]) begin
                lane_q[st_q.s2_addr] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end

        assign lane_rd[b*BYTE_W +: BYTE_W] = lane_q[st_q.s2_addr];
    end

    assign rdata   = st_q.q;
    assign rd_live = st_q.live;
    assign s2_op   = st_q.s2;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2,
    parameter int BYTES   = 4,
    parameter int BYTE_W  = 9,
    localparam int DATA_W = BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              cken_n,
    input  logic              adv_ld,
    input  logic              wr_n,
    input  logic [BYTES-1:0]  bw_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    logic              step;
    logic              chip_ok;
    logic              rd_live;
    op_e               s1_op;
    op_e               s2_op;
    op_e               burst_op;
    logic [ADDR_W-1:0] s1_addr;

    assign step    = ~cken_n;
    assign chip_ok = ~sel0_n & sel1 & ~sel2_n;

    burst_sram_seq #(
        .ADDR_W  (ADDR_W),
        .BURST_W (BURST_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .sleep    (sleep),
        .chip_ok  (chip_ok),
        .adv      (adv_ld),
        .rd_sel   (wr_n),
        .ext_addr (addr),
        .s1_op    (s1_op),
        .s1_addr  (s1_addr),
        .burst_op (burst_op)
    );

    burst_sram_array #(
        .ADDR_W (ADDR_W),
        .BYTES  (BYTES),
        .BYTE_W (BYTE_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .sleep   (sleep),
        .s1_op   (s1_op),
        .s1_addr (s1_addr),
        .wdata   (din),
        .wmask_n (bw_n),
        .rdata   (dout),
        .rd_live (rd_live),
        .s2_op   (s2_op)
    );

    assign dout_en = rd_live & ~oe_n & ~sleep;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2,
    parameter int DATA_W  = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel0_n,
    input logic              sel1,
    input logic              sel2_n,
    input logic              cken_n,
    input logic              adv_ld,
    input logic              wr_n,
    input logic              sleep,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input op_e               s1_op,
    input logic [ADDR_W-1:0] s1_addr,
    input op_e               burst_op,
    input op_e               s2_op
);

    logic sel_all;
    assign sel_all = ~sel0_n & sel1 & ~sel2_n;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (s1_op == OP_IDLE && s2_op == OP_IDLE && burst_op == OP_IDLE));

    assert_deselect_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cken_n && !sleep && !adv_ld && !sel_all) |=> (s1_op == OP_IDLE && burst_op == OP_IDLE));

    assert_continue_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cken_n && !sleep && adv_ld && burst_op == OP_IDLE) |=> (s1_op == OP_IDLE));

    assert_read_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cken_n && !sleep && !adv_ld && sel_all && wr_n) |=> (s1_op == OP_READ));

    assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cken_n && !sleep && adv_ld && burst_op != OP_IDLE) |=>
        (s1_addr[BURST_W-1:0] == BURST_W'($past(s1_addr[BURST_W-1:0]) + 1)
         && s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W])
         && s1_op == $past(burst_op)));

    assert_write_bus_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cken_n && !sleep && s2_op == OP_WRITE) |=> !dout_en);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cken_n && !sleep) |=> ($stable(dout) && $stable(s1_op) && $stable(s1_addr)
                                && $stable(s2_op) && $stable(burst_op)));

    assert_sleep_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (s1_op == OP_IDLE && s2_op == OP_IDLE && burst_op == OP_IDLE));

endmodule

bind burst_sram burst_sram_chk #(
    .ADDR_W  (ADDR_W),
    .BURST_W (BURST_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel0_n   (sel0_n),
    .sel1     (sel1),
    .sel2_n   (sel2_n),
    .cken_n   (cken_n),
    .adv_ld   (adv_ld),
    .wr_n     (wr_n),
    .sleep    (sleep),
    .dout     (dout),
    .dout_en  (dout_en),
    .s1_op    (s1_op),
    .s1_addr  (s1_addr),
    .burst_op (burst_op),
    .s2_op    (s2_op)
);

// File: tb/tb_burst_sram.sv
`timescale 1ns/1ps
module tb_burst_sram;

    localparam int AW = 6;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel0_n = 1'b1, sel1 = 1'b1, sel2_n = 1'b0;
    logic          cken_n = 1'b0, adv_ld = 1'b0, wr_n = 1'b1;
    logic [3:0]    bw_n = 4'hF;
    logic          oe_n = 1'b0, sleep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_chk = 0;
    int n_err = 0;
    logic [DW-1:0] shadow [64];

    always #5 clk = ~clk;

    burst_sram dut (
        .clk(clk), .rst_n(rst_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .cken_n(cken_n), .adv_ld(adv_ld), .wr_n(wr_n), .bw_n(bw_n), .oe_n(oe_n),
        .sleep(sleep), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [DW-1:0] pat(input int a, input int s);
        return DW'(a * 1237 + s * 40503) ^ 36'h9_A5C3_96E1;
    endfunction

    function automatic logic [AW-1:0] baddr(input int base, input int k);
        return AW'((base & ~3) | ((base + k) & 3));
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic sel_on();
        sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0;
    endtask

    task automatic idle_cmd();
        cken_n = 1'b0; adv_ld = 1'b0; wr_n = 1'b1;
        sel0_n = 1'b1; sel1 = 1'b1; sel2_n = 1'b0;
    endtask

    // Burst of len operations from base; opposite wr_n and junk addr on advances (R6).
    task automatic burst(input bit is_wr, input int base, input int len,
                         input logic [3:0] mask, input int salt, input string tag);
        logic [DW-1:0]  nd;
        logic [AW-1:0]  a;
        for (int i = 0; i < len + 2; i++) begin
            if (i < len) begin
                cken_n = 1'b0; sel_on();
                adv_ld = (i != 0);
                wr_n   = (i == 0) ? ~is_wr : is_wr;
                addr   = (i == 0) ? AW'(base) : AW'(base ^ 45);
            end else begin
                idle_cmd();
            end
            if (i >= 2) a = baddr(base, i - 2);
            if (is_wr && i >= 2) begin
                nd = pat(a, salt);
                din = nd; bw_n = mask;
                for (int b = 0; b < 4; b++)
                    if (!mask[b]) shadow[a][b*9 +: 9] = nd[b*9 +: 9];
            end else begin
                din = pat(99, salt + 7); bw_n = 4'h0;
            end
            tick();
            if (i >= 2) begin
                if (is_wr) begin
                    chk({tag, " R8 bus off"}, DW'(dout_en), DW'(0));
                end else begin
                    chk({tag, " R3 drive"}, DW'(dout_en), DW'(1));
                    chk({tag, " R3 data"}, dout, shadow[a]);
                end
            end
        end
    endtask

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [DW-1:0] nv;
        // R1: reset state
        idle_cmd();
        tick(); tick();
        chk("R1 reset dout_en", DW'(dout_en), DW'(0));
        rst_n = 1'b1;
        tick();
        // R1: advance after reset is continue-deselect
        sel_on(); adv_ld = 1'b1; wr_n = 1'b0; bw_n = 4'h0; din = pat(5, 5);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R1 advance after reset", DW'(dout_en), DW'(0));
        end
        idle_cmd(); tick(); tick();

        // R4 R6: write every word, bursts starting at every offset
        for (int g = 0; g < 16; g++) burst(1'b1, g*4 + (g % 4), 4, 4'h0, 1, "R4 R6 write");
        // R3 R6: read back with different offsets
        for (int g = 0; g < 16; g++) burst(1'b0, g*4 + ((g + 1) % 4), 4, 4'h0, 0, "R3 R6 read");
        burst(1'b0, 13, 3, 4'h0, 0, "R6 short");
        burst(1'b0, 30, 2, 4'h0, 0, "R6 short");

        // R4 R5: every strobe pattern on one word (4'hF is the abort)
        for (int m = 0; m < 16; m++) begin
            burst(1'b1, 37, 1, 4'(m), m + 3, "R4 R5 mask");
            burst(1'b0, 37, 1, 4'h0, 0, "R4 R5 readback");
        end

        // R7: dummy read and asynchronous output enable
        cken_n = 1'b0; sel_on(); adv_ld = 1'b0; wr_n = 1'b1; addr = 6'd50; tick();
        idle_cmd(); tick();
        oe_n = 1'b1; tick();
        chk("R7 dummy read released", DW'(dout_en), DW'(0));
        oe_n = 1'b0; #1;
        chk("R7 oe low drives", DW'(dout_en), DW'(1));
        chk("R7 data", dout, shadow[50]);
        tick(); tick();

        // R9: stall during a read burst
        cken_n = 1'b0; sel_on(); adv_ld = 1'b0; wr_n = 1'b1; addr = 6'd9; tick();
        adv_ld = 1'b1; tick();
        tick();
        chk("R9 first word", dout, shadow[9]);
        cken_n = 1'b1; adv_ld = 1'b0; wr_n = 1'b0; bw_n = 4'h0; din = pat(77, 77);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R9 stall holds drive", DW'(dout_en), DW'(1));
            chk("R9 stall holds data", dout, shadow[9]);
        end
        cken_n = 1'b0; adv_ld = 1'b1; wr_n = 1'b1; tick();
        chk("R9 resume word1", dout, shadow[10]);
        idle_cmd(); tick();
        chk("R9 resume word2", dout, shadow[11]);
        tick();
        chk("R9 resume word3 wrap R6", dout, shadow[8]);
        tick();

        // R9 R5: stall at a write data edge, then abort
        cken_n = 1'b0; sel_on(); adv_ld = 1'b0; wr_n = 1'b0; addr = 6'd17; tick();
        idle_cmd(); tick();
        cken_n = 1'b1; wr_n = 1'b0; din = pat(88, 88); bw_n = 4'h0;
        tick(); chk("R9 write stall released", DW'(dout_en), DW'(0));
        tick(); chk("R9 write stall released", DW'(dout_en), DW'(0));
        idle_cmd(); bw_n = 4'hF; tick();
        tick();
        burst(1'b0, 17, 1, 4'h0, 0, "R9 R5 unchanged");

        // R11: read right behind a write to the same word
        cken_n = 1'b0; sel_on(); adv_ld = 1'b0; wr_n = 1'b0; addr = 6'd60; tick();
        wr_n = 1'b1; din = pat(1, 1); bw_n = 4'h0; tick();
        idle_cmd(); nv = pat(60, 321); din = nv; bw_n = 4'h0; shadow[60] = nv; tick();
        din = pat(2, 2); tick();
        chk("R11 drive", DW'(dout_en), DW'(1));
        chk("R11 fresh data", dout, nv);
        tick();

        // R2: deselect by each chip select, then continue-deselect
        for (int v = 0; v < 3; v++) begin
            cken_n = 1'b0; adv_ld = 1'b0; wr_n = 1'b1; addr = AW'(20 + v);
            sel0_n = (v == 0); sel1 = (v != 1); sel2_n = (v == 2);
            tick(); chk("R2 deselect", DW'(dout_en), DW'(0));
            sel_on(); adv_ld = 1'b1;
            tick(); chk("R2 continue deselect", DW'(dout_en), DW'(0));
            tick(); chk("R2 continue deselect", DW'(dout_en), DW'(0));
            idle_cmd();
            tick(); chk("R2 continue deselect", DW'(dout_en), DW'(0));
        end
        cken_n = 1'b0; sel0_n = 1'b1; sel1 = 1'b1; sel2_n = 1'b0;
        adv_ld = 1'b0; wr_n = 1'b0; addr = 6'd22; din = pat(3, 3); bw_n = 4'h0; tick();
        sel_on(); adv_ld = 1'b1; tick(); tick();
        idle_cmd(); tick(); tick();
        burst(1'b0, 20, 4, 4'h0, 0, "R2 no write");

        // R10: sleep over an in-flight write
        cken_n = 1'b0; sel_on(); adv_ld = 1'b0; wr_n = 1'b0; addr = 6'd3; tick();
        sleep = 1'b1; adv_ld = 1'b1; din = pat(4, 4); bw_n = 4'h0;
        for (int i = 0; i < 3; i++) begin
            tick(); chk("R10 sleep released", DW'(dout_en), DW'(0));
        end
        sleep = 1'b0; adv_ld = 1'b1; wr_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick(); chk("R10 deselected after sleep", DW'(dout_en), DW'(0));
        end
        idle_cmd(); tick(); tick();
        burst(1'b0, 0, 4, 4'h0, 0, "R10 no write");

        // R10: sleep cuts an active read
        cken_n = 1'b0; sel_on(); adv_ld = 1'b0; wr_n = 1'b1; addr = 6'd44; tick();
        adv_ld = 1'b1; tick(); tick();
        chk("R10 pre-sleep drive", DW'(dout_en), DW'(1));
        sleep = 1'b1; #1;
        chk("R10 sleep releases at once", DW'(dout_en), DW'(0));
        tick(); chk("R10 sleep edge", DW'(dout_en), DW'(0));
        sleep = 1'b0; idle_cmd();
        tick(); chk("R10 flushed", DW'(dout_en), DW'(0));
        tick(); chk("R10 flushed", DW'(dout_en), DW'(0));

        // R1: second reset keeps storage, advances after it write nothing
        rst_n = 1'b0; tick();
        chk("R1 reset dout_en", DW'(dout_en), DW'(0));
        rst_n = 1'b1; tick();
        sel_on(); adv_ld = 1'b1; wr_n = 1'b0; bw_n = 4'h0; din = pat(6, 6);
        for (int i = 0; i < 4; i++) tick();
        idle_cmd(); tick(); tick();
        burst(1'b0, 0, 4, 4'h0, 0, "R1 storage kept");

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule